// File: doc/BRIEF.md
# Absolute-to-Physical Address Mapper

This block turns an absolute address into a physical address. It is used on the data path of a processor whenever virtual translation is switched off. A 64-bit absolute address enters together with two flags. The wide-mode flag selects the 64-bit addressing view. The architecture flag chooses between the older scheme, which has plain 32-bit addressing, and the newer scheme, which has narrow-mode regions. The block returns a physical address that is sign-extended from its implemented width `PHYS_W` (at most 54) to 64 bits. It also returns a 2-bit region code and a read/write/execute permission triple.

In narrow mode on the newer scheme, the top two nibbles of the low word pick the region. If the upper nibble is anything other than all ones, the address is plain memory and is zero-extended. If that nibble is all ones and the next nibble is nonzero, the address is in the I/O window and is sign-extended. If that nibble is all ones and the next nibble is zero, the address is a 16 MiB firmware window, which is relocated to the top of physical space. The result is registered by default and appears one cycle after the input strobe. It stays held until the next strobe.

Top module: `abs_phys_map`

## Requirements
- R1: With wideMode=1 (either architecture), physAddr equals absAddr[PHYS_W-1:0] sign-extended to 64 bits, and region is 3.
- R2: With wideMode=0 and newArch=1, when absAddr[31:28] is not 4'hF, physAddr is {32'b0, absAddr[31:0]} and region is 0. Bits 63:32 of the input have no effect.
- R3: With wideMode=0 and newArch=1, when absAddr[31:28]=4'hF and absAddr[27:24]≠0, physAddr is absAddr[31:0] sign-extended to 64 bits (so bits 63:32 are all ones) and region is 1.
- R4: With wideMode=0 and newArch=1, when absAddr[31:24]=8'hF0, the output is built as follows. physAddr[23:0] equals absAddr[23:0]. Bits PHYS_W-5 down to 24 are zero. Bits 63 down to PHYS_W-4 are one. Region is 2.
- R5: With wideMode=0 and newArch=0, physAddr is {32'b0, absAddr[31:0]} for every address, including those whose top nibble is 4'hF. Region is 0.
- R6: permRwx is 3'b111 (bit 2 read, bit 1 write, bit 0 execute) whenever outValid is 1.
- R7: When the register stage is enabled (the default), outValid is 1 exactly in the cycle after a cycle in which inValid was 1, and the outputs carry that input's result. After reset, outValid, physAddr, region and permRwx are all zero.
- R8: While inValid is 0, physAddr, region and permRwx keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input address is valid this cycle |
| absAddr | input | ADDR_W (64) | Absolute address |
| wideMode | input | 1 | 1 selects 64-bit wide addressing |
| newArch | input | 1 | 1 selects the newer scheme with narrow-mode regions |
| outValid | output | 1 | Result valid strobe |
| physAddr | output | ADDR_W (64) | Physical address, sign-extended from PHYS_W |
| region | output | 2 | 0 memory, 1 I/O, 2 firmware, 3 wide |
| permRwx | output | 3 | Granted read/write/execute |

## Verification
The bench drives addresses on both sides of every nibble boundary: 0xEFFFFFFF against 0xF0000000, 0xF0FFFFFF against 0xF1000000, and 0xFFFFFFFF. It does this with junk in the upper word, under both flags and in both modes. A decoder that tested the wrong nibble or the wrong compare sense would give 0xF0FFFFFF an I/O tag. It would also sign-extend into memory space, or leave the firmware window at a low address. In wide mode, bit PHYS_W-1 is toggled. A wrong extension point shows up as a corrupted upper word. The bench also applies idle cycles with changing inputs. A register that reloaded without a strobe would then show new data.

// File: rtl/absmap_pkg.sv
package absmap_pkg;

  typedef enum logic [1:0] {
    RGN_MEM  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_FW   = 2'd2,
    RGN_WIDE = 2'd3
  } region_e;

  typedef struct packed {
    logic capture;
  } ctl_strb_t;

endpackage

// File: rtl/absmap_ctrl.sv
module absmap_ctrl #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output absmap_pkg::ctl_strb_t strb,
  output logic                  outValid
);

  assign strb.capture = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
      assign outValid  = inValid;
    end
  endgenerate

endmodule

// File: rtl/absmap_dpath.sv
module absmap_dpath #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned PHYS_W  = 40,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  absmap_pkg::ctl_strb_t strb,
  input  logic [ADDR_W-1:0]     absAddr,
  input  logic                  wideMode,
  input  logic                  newArch,
  output logic [ADDR_W-1:0]     physAddr,
  output logic [1:0]            region,
  output logic [2:0]            permRwx
);
  import absmap_pkg::*;

  localparam int unsigned LOW_W  = 32;
  localparam int unsigned FW_W   = 24;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned FW_TOP = PHYS_W - NIB_W;
  localparam logic [ADDR_W-1:0] FW_MASK = ~((ADDR_W'(1) << FW_TOP) - ADDR_W'(1));

  logic [ADDR_W-1:0] mapD;
  region_e           rgnD;
  logic [NIB_W-1:0]  hiNib, subNib;
  logic [LOW_W-1:0]  lowWord;
  logic              unusedHi;

  assign lowWord  = absAddr[LOW_W-1:0];
  assign hiNib    = lowWord[LOW_W-1 -: NIB_W];
  assign subNib   = lowWord[LOW_W-NIB_W-1 -: NIB_W];
  assign unusedHi = ^absAddr[ADDR_W-1:LOW_W];

  always_comb begin
    if (wideMode) begin
      rgnD = RGN_WIDE;
      mapD = {{(ADDR_W-PHYS_W){absAddr[PHYS_W-1]}}, absAddr[PHYS_W-1:0]};
    end else if (!newArch || hiNib != '1) begin
      rgnD = RGN_MEM;
      mapD = {{(ADDR_W-LOW_W){1'b0}}, lowWord};
    end else if (subNib != '0) begin
      rgnD = RGN_IO;
      mapD = {{(ADDR_W-LOW_W){lowWord[LOW_W-1]}}, lowWord};
    end else begin
      rgnD = RGN_FW;
      mapD = FW_MASK | {{(ADDR_W-FW_W){1'b0}}, lowWord[FW_W-1:0]};
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [ADDR_W-1:0] physQ;
      logic [1:0]        rgnQ;
      logic [2:0]        permQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          physQ <= '0;
          rgnQ  <= '0;
          permQ <= '0;
        end else if (strb.capture) begin
          physQ <= mapD;
          rgnQ  <= rgnD;
          permQ <= 3'b111;
        end
      end
      assign physAddr = physQ;
      assign region   = rgnQ;
      assign permRwx  = permQ;
    end else begin : g_comb
      logic unusedCtl;
      assign unusedCtl = clk ^ rstN ^ strb.capture;
      assign physAddr  = mapD;
      assign region    = rgnD;
      assign permRwx   = 3'b111;
    end
  endgenerate

endmodule

// File: rtl/abs_phys_map.sv
module abs_phys_map #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned PHYS_W  = 40,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] absAddr,
  input  logic              wideMode,
  input  logic              newArch,
  output logic              outValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [1:0]        region,
  output logic [2:0]        permRwx
);

  absmap_pkg::ctl_strb_t strb;

  absmap_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strb(strb), .outValid(outValid)
  );

  absmap_dpath #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .REG_OUT(REG_OUT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .absAddr(absAddr),
    .wideMode(wideMode), .newArch(newArch),
    .physAddr(physAddr), .region(region), .permRwx(permRwx)
  );

endmodule

// File: rtl/abs_phys_map_chk.sv
module abs_phys_map_chk #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned PHYS_W  = 40,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic [ADDR_W-1:0] physAddr,
  input logic [1:0]        region,
  input logic [2:0]        permRwx
);

  initial begin
    assert (PHYS_W <= 54 && PHYS_W > 24 + 4 && ADDR_W >= PHYS_W);
  end

  // R7
  valid_follows_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R6
  perm_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> permRwx == 3'b111);

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(physAddr) && $stable(region) && $stable(permRwx));

  // R1
  wide_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && region == 2'd3) |->
      ((&physAddr[ADDR_W-1:PHYS_W-1]) || !(|physAddr[ADDR_W-1:PHYS_W-1])));

  // R4
  fw_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && region == 2'd2) |-> (&physAddr[ADDR_W-1:PHYS_W-4]));

  // R2
  mem_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && region == 2'd0) |-> physAddr[ADDR_W-1:32] == '0);

  // R3
  io_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && region == 2'd1) |-> (&physAddr[ADDR_W-1:31]));

endmodule

bind abs_phys_map abs_phys_map_chk #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .physAddr(physAddr), .region(region), .permRwx(permRwx)
);

// File: tb/abs_phys_map_tb.sv
`timescale 1ns/1ps
module abs_phys_map_tb;

  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] absAddr = '0;
  logic        wideMode = 1'b0;
  logic        newArch = 1'b1;
  logic        outValid;
  logic [63:0] physAddr;
  logic [1:0]  region;
  logic [2:0]  permRwx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  abs_phys_map #(.ADDR_W(64), .PHYS_W(N), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .absAddr(absAddr),
    .wideMode(wideMode), .newArch(newArch), .outValid(outValid),
    .physAddr(physAddr), .region(region), .permRwx(permRwx)
  );

  // behavioural reference
  function automatic void refMap(input logic [63:0] a, input logic w, input logic na,
                                 output logic [63:0] p, output logic [1:0] r,
                                 output string tag);
    logic [31:0] lo;
    lo = a[31:0];
    if (w) begin
      p = 64'($signed(a << (64 - N)) >>> (64 - N)); r = 2'd3; tag = "R1";
    end else if (!na) begin
      p = 64'(lo); r = 2'd0; tag = "R5";
    end else if (lo < 32'hF000_0000) begin
      p = 64'(lo); r = 2'd0; tag = "R2";
    end else if (lo >= 32'hF100_0000) begin
      p = 64'($signed(lo)); r = 2'd1; tag = "R3";
    end else begin
      p = (64'hFFFF_FFFF_FFFF_FFFF << (N - 4)) + 64'(lo - 32'hF000_0000);
      r = 2'd2; tag = "R4";
    end
  endfunction

  logic        expValid = 1'b0;
  logic [63:0] expPhys  = '0;
  logic [1:0]  expRgn   = '0;
  logic [2:0]  expPerm  = '0;
  string       expTag   = "R7";

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0; expPhys <= '0; expRgn <= '0; expPerm <= '0; expTag <= "R7";
    end else begin
      expValid <= inValid;
      if (inValid) begin
        logic [63:0] p; logic [1:0] r; string t;
        refMap(absAddr, wideMode, newArch, p, r, t);
        expPhys <= p; expRgn <= r; expPerm <= 3'b111; expTag <= t;
      end else begin
        expTag <= "R8";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (outValid !== expValid) begin
        failures++;
        $display("FAIL R7 outValid act=%0b exp=%0b", outValid, expValid);
      end
      checks++;
      if (physAddr !== expPhys || region !== expRgn) begin
        failures++;
        $display("FAIL %s phys act=%h exp=%h region act=%0d exp=%0d",
                 expTag, physAddr, expPhys, region, expRgn);
      end
      checks++;
      if (permRwx !== expPerm) begin
        failures++;
        $display("FAIL R6 perm act=%b exp=%b", permRwx, expPerm);
      end
    end
  end

  task automatic send(input logic [63:0] a, input logic w, input logic na);
    @(negedge clk);
    inValid = 1'b1; absAddr = a; wideMode = w; newArch = na;
  endtask

  task automatic idle(input logic [63:0] junk);
    @(negedge clk);
    inValid = 1'b0; absAddr = junk; wideMode = junk[0]; newArch = junk[1];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset values checked by the negedge monitor while rstN is low
    rstN = 1'b1;
    // R2 / R3 / R4 boundaries, junk in the upper word
    send(64'hDEAD_BEEF_EFFF_FFFF, 1'b0, 1'b1);
    send(64'h1234_5678_F000_0000, 1'b0, 1'b1);
    send(64'h0000_0000_F0FF_FFFF, 1'b0, 1'b1);
    send(64'hFFFF_FFFF_F100_0000, 1'b0, 1'b1);
    send(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1);
    send(64'hA5A5_A5A5_F0AB_CDEF, 1'b0, 1'b1);
    send(64'h0, 1'b0, 1'b1);
    send(64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1);
    // R5: older scheme ignores the window decode
    send(64'hFFFF_0000_F000_0000, 1'b0, 1'b0);
    send(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0);
    send(64'h0000_0000_F123_4567, 1'b0, 1'b0);
    // R1: wide mode, toggling bit N-1
    send(64'h0000_007F_FFFF_FFFF, 1'b1, 1'b1);
    send(64'h0000_0080_0000_0000, 1'b1, 1'b1);
    send(64'hFFFF_FF80_0000_0001, 1'b1, 1'b0);
    send(64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0);
    send(64'h0000_0000_F000_0000, 1'b1, 1'b1);
    // R8: idle cycles with changing inputs
    idle(64'hFFFF_FFFF_FFFF_FFFF);
    idle(64'h0000_0000_F000_0003);
    idle(64'h1111_2222_3333_4442);
    send(64'h0000_0000_F0FF_FFFF, 1'b0, 1'b1);
    idle(64'h0);
    idle(64'h0000_0000_F100_0001);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      a = {$urandom(), $urandom()};
      if (i % 4 == 0) a[31:24] = 8'hF0;
      if (i % 4 == 1) a[31:28] = 4'hF;
      if ($urandom_range(0, 4) == 0) idle(a);
      else send(a, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0));
    end
    idle(64'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule